// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of interrupt request lines into a vector of raw pending bits. Each source is set up on its own to one of five trigger modes: active-high level, active-low level, rising edge, falling edge or any edge. A level source's pending bit follows its input, inverted or not, and is recomputed on every clock. An edge source's pending bit is latched when the selected transition appears and stays set until software-side logic clears it through the clear port.

The block holds three configuration vectors: level/edge choice, polarity/direction, and an any-edge override. They come out of reset with fixed per-source defaults and are replaced as a whole by a one-cycle load strobe. It also keeps a registered copy of every input, taken on every clock, and uses it to find transitions. Enable masking, priority routing and bus decoding belong to the logic that consumes the raw vector. The inputs must already be synchronous to `clk`.

Top module: `irq_trig_detect`

## Requirements
- R1: The block handles NUM_SRC sources (default 51, indexed 0 to 50), and bit i of every vector port belongs to source i.
- R2: A source with sense bit 1 and event bit 1 is active-high level: its pending bit, one clock after a sample, equals the input sampled at that edge.
- R3: A source with sense bit 1 and event bit 0 is active-low level: its pending bit, one clock after a sample, equals the inverse of the input sampled at that edge.
- R4: A source with sense 0, dual 0 and event 1 sets its pending bit one clock after the input is sampled at 1 where the previous sample was 0.
- R5: A source with sense 0, dual 0 and event 0 sets its pending bit one clock after the input is sampled at 0 where the previous sample was 1.
- R6: A source with sense 0 and dual 1 sets its pending bit on any difference between the previous and current sample, whatever its event bit.
- R7: An edge source's pending bit, once set, stays set until it is cleared, even after the input goes back to its earlier level.
- R8: The stored previous level of every source takes the input on every clock whatever its configuration, so a source switched from level to edge while its input is steady finds no edge.
- R9: A clear bit of 1 on clr_pend drops the pending bit of that source on the next clock only if the source is edge-configured; level sources ignore it.
- R10: When a clear and a detected edge hit the same source in one cycle, the edge wins and the pending bit is 1.
- R11: Reset sets sense to 0x1F07FFF8FFFF, event to 0x5F07FFF8FFFF and dual to 0xF800070000 (bit i is source i), and clears both the pending and the previous-level vectors.
- R12: With cfg_load high, all three configuration vectors take cfg_sense, cfg_event and cfg_dual at that clock edge; the detection in that same cycle still uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_SRC | Interrupt request lines, one per source |
| clr_pend | input | NUM_SRC | Per-source clear request for latched edge events |
| cfg_load | input | 1 | Loads the three configuration vectors at this edge |
| cfg_sense | input | NUM_SRC | New sense vector: 1 level, 0 edge |
| cfg_event | input | NUM_SRC | New event vector: 1 high or rising, 0 low or falling |
| cfg_dual | input | NUM_SRC | New any-edge vector, used only when the source is edge-configured |
| raw_pend | output | NUM_SRC | Raw pending vector |

## Verification
On every clock the assertions check that the stored previous level is the last sample, that level sources follow their input through the configured polarity, that an uncleared edge bit never drops, that a clear without a coincident edge empties an edge bit, that a new edge always lands, and that the configuration moves only on a load. What only the bench scenarios show is the choice of the right transition per mode, the reset configuration seen through behaviour, the use of the old configuration in the loading cycle, and the missing edge after a level-to-edge switch on a steady input. A behavioural reference model follows every source through long random stretches of inputs, clears and configuration loads.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int unsigned SRC_COUNT = 51;

  // Reset configuration, bit i belongs to source i.
  localparam logic [SRC_COUNT-1:0] SENSE_RST = 51'h1F07FFF8FFFF;
  localparam logic [SRC_COUNT-1:0] EVENT_RST = 51'h5F07FFF8FFFF;
  localparam logic [SRC_COUNT-1:0] DUAL_RST  = 51'h00F800070000;

  // Level value seen by a level source: polarity 1 passes the input through.
  function automatic logic lvl_bit(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

  // Transition detector for one source.
  function automatic logic edge_bit(input logic prev, input logic cur,
                                    input logic pol, input logic both);
    if (both)     return prev ^ cur;
    else if (pol) return ~prev & cur;
    else          return prev & ~cur;
  endfunction

  // Next pending value: level follows, edge latches, a new edge beats a clear.
  function automatic logic pend_bit(input logic held, input logic sense,
                                    input logic lvl, input logic edg,
                                    input logic clr);
    if (sense) return lvl;
    return edg | (held & ~clr);
  endfunction

endpackage

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
  parameter int unsigned NUM_SRC = 51,
  parameter logic [NUM_SRC-1:0] SENSE_INIT = '0,
  parameter logic [NUM_SRC-1:0] EVENT_INIT = '0,
  parameter logic [NUM_SRC-1:0] DUAL_INIT  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NUM_SRC-1:0] sense_d,
  input  logic [NUM_SRC-1:0] event_d,
  input  logic [NUM_SRC-1:0] dual_d,
  output logic [NUM_SRC-1:0] sense_q,
  output logic [NUM_SRC-1:0] event_q,
  output logic [NUM_SRC-1:0] dual_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= SENSE_INIT;
      event_q <= EVENT_INIT;
      dual_q  <= DUAL_INIT;
    end else if (load) begin
      sense_q <= sense_d;
      event_q <= event_d;
      dual_q  <= dual_d;
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_cfg_load_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(load) |-> (sense_q == $past(sense_d) && event_q == $past(event_d)
                     && dual_q == $past(dual_d)));

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(load) |-> ($stable(sense_q) && $stable(event_q) && $stable(dual_q)));

endmodule

// File: rtl/irq_trig_sense.sv
module irq_trig_sense
  import irq_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 51
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] both,
  output logic [NUM_SRC-1:0] prev_q,
  output logic [NUM_SRC-1:0] lvl_val,
  output logic [NUM_SRC-1:0] edge_hit
);

  // Previous level is refreshed every clock regardless of configuration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign lvl_val[i]  = lvl_bit(src[i], pol[i]);
    assign edge_hit[i] = edge_bit(prev_q[i], src[i], pol[i], both[i]);
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_prev_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    prev_q == $past(src));

endmodule

// File: rtl/irq_trig_pend.sv
module irq_trig_pend
  import irq_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 51
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sense,
  input  logic [NUM_SRC-1:0] lvl_val,
  input  logic [NUM_SRC-1:0] edge_hit,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] raw_q
);

  logic [NUM_SRC-1:0] raw_next;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign raw_next[i] = pend_bit(raw_q[i], sense[i], lvl_val[i], edge_hit[i], clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next;
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // Uncleared edge bits never drop.
  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(raw_q) & ~$past(sense) & ~$past(clr)) & ~raw_q) == '0);

  // A clear with no coincident edge empties an edge bit.
  assert_clear_edge_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(clr) & ~$past(sense) & ~$past(edge_hit)) & raw_q) == '0);

  // A detected edge always lands, clear or not.
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(edge_hit) & ~$past(sense)) & ~raw_q) == '0);

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import irq_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter logic [NUM_SRC-1:0] SENSE_INIT = NUM_SRC'(SENSE_RST),
  parameter logic [NUM_SRC-1:0] EVENT_INIT = NUM_SRC'(EVENT_RST),
  parameter logic [NUM_SRC-1:0] DUAL_INIT  = NUM_SRC'(DUAL_RST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_pend,
  input  logic               cfg_load,
  input  logic [NUM_SRC-1:0] cfg_sense,
  input  logic [NUM_SRC-1:0] cfg_event,
  input  logic [NUM_SRC-1:0] cfg_dual,
  output logic [NUM_SRC-1:0] raw_pend
);

  logic [NUM_SRC-1:0] sense_q, event_q, dual_q;
  logic [NUM_SRC-1:0] prev_q, lvl_val, edge_hit;

  irq_trig_cfg #(
    .NUM_SRC(NUM_SRC), .SENSE_INIT(SENSE_INIT),
    .EVENT_INIT(EVENT_INIT), .DUAL_INIT(DUAL_INIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .sense_d(cfg_sense), .event_d(cfg_event), .dual_d(cfg_dual),
    .sense_q(sense_q), .event_q(event_q), .dual_q(dual_q)
  );

  irq_trig_sense #(.NUM_SRC(NUM_SRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .src(irq_in), .pol(event_q), .both(dual_q),
    .prev_q(prev_q), .lvl_val(lvl_val), .edge_hit(edge_hit)
  );

  irq_trig_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .sense(sense_q), .lvl_val(lvl_val),
    .edge_hit(edge_hit), .clr(clr_pend), .raw_q(raw_pend)
  );

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // Level sources track the input through their polarity (R2 high, R3 low).
  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((raw_pend ^ ($past(irq_in) ~^ $past(event_q))) & $past(sense_q)) == '0);

endmodule

// File: tb/irq_trig_detect_test.sv
`timescale 1ns/1ps
module irq_trig_detect_test;

  localparam int N = 51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] d_src = '0, d_clr = '0, d_sense = '0, d_event = '0, d_dual = '0;
  logic d_load = 1'b0;
  logic [N-1:0] raw_pend;

  always #5 clk = ~clk;

  irq_trig_detect uut (
    .clk(clk), .rst_n(rst_n), .irq_in(d_src), .clr_pend(d_clr),
    .cfg_load(d_load), .cfg_sense(d_sense), .cfg_event(d_event),
    .cfg_dual(d_dual), .raw_pend(raw_pend)
  );

  int checks = 0;
  int fails  = 0;

  // Reference state
  bit m_raw[N], m_prev[N], m_s[N], m_e[N], m_d[N];
  bit n_raw[N];

  function automatic string mode_tag(int i);
    if (m_s[i]) return m_e[i] ? "R2" : "R3";
    if (m_d[i]) return "R6";
    return m_e[i] ? "R4" : "R5";
  endfunction

  task automatic model_reset();
    logic [N-1:0] s0, e0, d0;
    s0 = 51'h1F07FFF8FFFF; e0 = 51'h5F07FFF8FFFF; d0 = 51'h00F800070000;
    for (int i = 0; i < N; i++) begin
      m_raw[i] = 0; m_prev[i] = 0;
      m_s[i] = s0[i]; m_e[i] = e0[i]; m_d[i] = d0[i];
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      bit cur, hit;
      cur = d_src[i];
      if (m_s[i]) begin
        n_raw[i] = m_e[i] ? cur : !cur;
      end else begin
        if (m_d[i])      hit = (m_prev[i] != cur);
        else if (m_e[i]) hit = (!m_prev[i] && cur);
        else             hit = (m_prev[i] && !cur);
        if (hit)           n_raw[i] = 1;
        else if (d_clr[i]) n_raw[i] = 0;
        else               n_raw[i] = m_raw[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      m_raw[i]  = n_raw[i];
      m_prev[i] = d_src[i];
      if (d_load) begin
        m_s[i] = d_sense[i]; m_e[i] = d_event[i]; m_d[i] = d_dual[i];
      end
    end
  endtask

  task automatic compare();
    int bad;
    bad = -1;
    for (int i = N - 1; i >= 0; i--) if (raw_pend[i] !== m_raw[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s source %0d: got %b expected %b (t=%0t)",
               mode_tag(bad), bad, raw_pend[bad], m_raw[bad], $time);
    end
  endtask

  task automatic chk(int idx, bit exp, string tag);
    checks++;
    if (raw_pend[idx] !== exp) begin
      fails++;
      $display("FAIL %s source %0d: got %b expected %b", tag, idx, raw_pend[idx], exp);
    end
  endtask

  // Inputs were set at a falling edge; model and design both see them at the rising edge.
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic load_cfg(logic [N-1:0] s, logic [N-1:0] e, logic [N-1:0] d);
    d_sense = s; d_event = e; d_dual = d; d_load = 1'b1;
    tick();
    d_load = 1'b0;
  endtask

  logic [N-1:0] cs, ce, cd;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R11: pending vector is zero in reset
    repeat (3) @(negedge clk);
    checks++;
    if (raw_pend !== '0) begin
      fails++;
      $display("FAIL R11 reset raw: got %h expected 0", raw_pend);
    end
    // R1: one pending bit per source
    checks++;
    if ($bits(raw_pend) != 51) begin
      fails++;
      $display("FAIL R1 width: got %0d expected 51", $bits(raw_pend));
    end
    rst_n = 1'b1;
    model_reset();
    tick(); tick();

    // R11: reset configuration and zero previous level seen through behaviour
    d_src = '1;
    tick();
    chk(0, 1, "R11");   // level-high by default
    chk(16, 1, "R11");  // any-edge by default, prior level 0
    chk(46, 1, "R11");  // rising by default
    chk(45, 0, "R11");  // falling by default
    d_src = '0;
    tick();
    chk(45, 1, "R11");

    // Custom pattern: mode = i % 5 -> lvl high, lvl low, rise, fall, any
    for (int i = 0; i < N; i++) begin
      cs[i] = (i % 5) < 2;
      ce[i] = ((i % 5) == 0) || ((i % 5) == 2);
      cd[i] = (i % 5) == 4;
    end
    load_cfg(cs, ce, cd);
    d_clr = '1; tick(); d_clr = '0;
    tick();
    chk(1, 1, "R3"); chk(0, 0, "R2"); chk(2, 0, "R4");

    d_src = (N'(1) << 0) | (N'(1) << 2) | (N'(1) << 4);
    tick();
    chk(0, 1, "R2"); chk(2, 1, "R4"); chk(4, 1, "R6"); chk(1, 1, "R3");
    d_src = '0;
    tick();
    chk(0, 0, "R2"); chk(2, 1, "R7"); chk(4, 1, "R7");

    d_src = N'(1) << 3;
    tick();
    chk(3, 0, "R5");
    d_src = '0;
    tick();
    chk(3, 1, "R5");

    d_clr = '1;
    tick();
    d_clr = '0;
    chk(2, 0, "R9"); chk(4, 0, "R9"); chk(3, 0, "R9"); chk(1, 1, "R9");

    d_src = N'(1) << 2; d_clr = N'(1) << 2;
    tick();
    d_clr = '0;
    chk(2, 1, "R10");

    d_src = N'(1) << 4;
    tick();
    chk(4, 1, "R6");
    d_clr = N'(1) << 4;
    tick();
    d_clr = '0;
    chk(4, 0, "R9");
    d_src = '0;
    tick();
    chk(4, 1, "R6");

    // R8 and R12: source 5 level-high to rising with steady high input;
    // source 6 level-low to level-high with input low.
    d_src = N'(1) << 5;
    tick(); tick();
    chk(5, 1, "R2");
    cs[5] = 1'b0; ce[5] = 1'b1;
    ce[6] = 1'b1;
    load_cfg(cs, ce, cd);
    chk(6, 1, "R12");
    tick();
    chk(6, 0, "R12");
    d_clr = N'(1) << 5;
    tick();
    d_clr = '0;
    chk(5, 0, "R8");
    tick(); tick();
    chk(5, 0, "R8");

    // Random stretch with clears and occasional reconfiguration
    for (int k = 0; k < 600; k++) begin
      d_src = N'({$urandom, $urandom});
      d_clr = (($urandom % 4) == 0) ? N'({$urandom, $urandom}) : '0;
      if ((k % 60) == 59) begin
        d_sense = N'({$urandom, $urandom});
        d_event = N'({$urandom, $urandom});
        d_dual  = N'({$urandom, $urandom});
        d_load  = 1'b1;
      end
      tick();
      d_load = 1'b0;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule